// File: doc/BRIEF.md
# Video-Memory Block Copy Engine

This block copies data in 16-byte blocks from any location in a 16-bit address space into an 8 KB video-memory window. Software sets the start addresses and a block count through five byte-wide registers. Writing the control register with its mode bit clear starts a copy. The CPU is held off for the whole copy. The engine then reads each source byte and writes it to the window over a simple request/acknowledge memory port. Its pacing between bytes depends on whether the system runs in its doubled-speed mode.

When the copy ends, the source and destination registers hold the addresses just past the copied data. The block count reads back as all ones. If the control register is written with its mode bit set, the count and the mode are stored but nothing moves. This records a deferred, per-line request that is served elsewhere.

Top module: `vram_block_dma`

## Requirements
- R1: Registers are selected by `reg_sel`: 0 = source high byte, 1 = source low byte, 2 = destination high byte, 3 = destination low byte, 4 = control. `reg_rdata` presents the selected register one cycle after `reg_sel` is applied, and any other selector value reads as 0.
- R2: Writes to the two low-byte registers (selectors 1 and 3) keep bits 7:4 only, so bits 3:0 of both addresses always read 0.
- R3: A control write stores bits 6:0 as the block count and bit 7 as the mode. A control read returns the count in bits 6:0 and the mode in bit 7.
- R4: A control write with bit 7 = 0 copies (count + 1) × 16 bytes in ascending order. Byte k is read from source + k (16-bit wraparound) and then written unchanged to its destination.
- R5: The destination of byte k is 0x8000 | ((destination + k) & 0x1FFF), so writes wrap inside 0x8000–0x9FFF.
- R6: A copy starts with one wait step of `STEP_CYCLES` idle cycles. After that, one more wait step comes before every byte while `hi_speed` = 1, and before odd-numbered bytes only while `hi_speed` = 0. With a memory that acknowledges at once, `cpu_stall` is high for STEP_CYCLES + 2·N + STEP_CYCLES·W cycles, where N is the byte count and W is the number of waited bytes.
- R7: After a copy, source and destination have each grown by N (16-bit wraparound), the count reads 0x7F and the mode bit reads 0.
- R8: A control write with bit 7 = 1 stores count and mode but raises no memory request and no stall, and leaves the addresses unchanged.
- R9: `cpu_stall` rises in the cycle after the starting control write and falls in the cycle after the last write is acknowledged.
- R10: Register writes made while `cpu_stall` is high have no effect.
- R11: A request holds `mem_addr`, `mem_we` and `mem_wdata` steady until `mem_ack`. Each acknowledge completes exactly one access.
- R12: After reset, all registers read 0 and `cpu_stall` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register selector |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| hi_speed | input | 1 | Doubled-speed system mode |
| cpu_stall | output | 1 | Holds the CPU while copying |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid with acknowledge |
| mem_ack | input | 1 | Single-cycle acknowledge |

## Verification
The bench builds the block with `STEP_CYCLES` = 2 and the default 16-byte blocks and 0x8000/0x1FFF window. Short wait steps keep even the largest copy of 2048 bytes within the run budget. They also make the exact stall-length formula easy to compare in both speed modes. Window wrap at 0x9FFF and 16-bit source and register wrap past 0xFFFF are reached with small block counts. Random acknowledge delays exercise request holding.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 2 * REG_W;
  localparam int LEN_W  = REG_W - 1;
  localparam int SEL_W  = 3;

  localparam logic [SEL_W-1:0] SEL_SRC_HI = 3'd0;
  localparam logic [SEL_W-1:0] SEL_SRC_LO = 3'd1;
  localparam logic [SEL_W-1:0] SEL_DST_HI = 3'd2;
  localparam logic [SEL_W-1:0] SEL_DST_LO = 3'd3;
  localparam logic [SEL_W-1:0] SEL_CTL    = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PACE,
    ST_RD,
    ST_WR
  } xfer_state_e;
endpackage

// File: rtl/vdma_regs.sv
module vdma_regs
  import vdma_pkg::*;
#(
  parameter int BLK_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              busy,
  input  logic              done,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              start,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic [LEN_W-1:0]  len_q
);
  localparam int CNT_W = LEN_W + 1 + BLK_SHIFT;
  localparam logic [REG_W-1:0] LO_MASK = REG_W'({REG_W{1'b1}} << BLK_SHIFT);

  logic             mode_q;
  logic             wr_ok;
  logic [CNT_W-1:0] count;

  assign wr_ok = reg_wr && !busy;
  assign start = wr_ok && (reg_sel == SEL_CTL) && !reg_wdata[REG_W-1];
  assign count = (CNT_W'(len_q) + CNT_W'(1)) << BLK_SHIFT;

  // Register updates: completion has priority, writes are dropped while busy.
  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      dst_q  <= '0;
      len_q  <= '0;
      mode_q <= 1'b0;
    end else if (done) begin
      src_q <= src_q + ADDR_W'(count);
      dst_q <= dst_q + ADDR_W'(count);
      len_q <= '1;
    end else if (wr_ok) begin
      case (reg_sel)
        SEL_SRC_HI: src_q[ADDR_W-1:REG_W] <= reg_wdata;
        SEL_SRC_LO: src_q[REG_W-1:0]      <= reg_wdata & LO_MASK;
        SEL_DST_HI: dst_q[ADDR_W-1:REG_W] <= reg_wdata;
        SEL_DST_LO: dst_q[REG_W-1:0]      <= reg_wdata & LO_MASK;
        SEL_CTL: begin
          len_q  <= reg_wdata[LEN_W-1:0];
          mode_q <= reg_wdata[REG_W-1];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_sel)
        SEL_SRC_HI: reg_rdata <= src_q[ADDR_W-1:REG_W];
        SEL_SRC_LO: reg_rdata <= src_q[REG_W-1:0];
        SEL_DST_HI: reg_rdata <= dst_q[ADDR_W-1:REG_W];
        SEL_DST_LO: reg_rdata <= dst_q[REG_W-1:0];
        SEL_CTL:    reg_rdata <= {mode_q, len_q};
        default:    reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/vdma_pacer.sv
module vdma_pacer #(
  parameter int STEP_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic tick
);
  localparam int CW = (STEP_CYCLES < 2) ? 1 : $clog2(STEP_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= CW'(STEP_CYCLES - 1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign tick = (cnt_q == '0);
endmodule

// File: rtl/vdma_engine.sv
module vdma_engine
  import vdma_pkg::*;
#(
  parameter int                BLK_SHIFT = 4,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 16'h8000,
  parameter logic [ADDR_W-1:0] WIN_MASK  = 16'h1FFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              hi_speed,
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  input  logic [LEN_W-1:0]  len,
  input  logic              tick,
  output logic              load_wait,
  output logic              done,
  output logic              stall,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [REG_W-1:0]  mem_wdata,
  input  logic [REG_W-1:0]  mem_rdata,
  input  logic              mem_ack
);
  localparam int IDX_W = LEN_W + BLK_SHIFT;

  xfer_state_e      state_q, state_n;
  logic [IDX_W-1:0] idx_q, idx_n, idx_inc;
  logic             last;
  logic [ADDR_W-1:0] rd_addr_n, wr_addr_n;

  function automatic logic wants_wait(input logic hs, input logic [IDX_W-1:0] k);
    return hs | k[0];
  endfunction

  assign idx_inc = idx_q + IDX_W'(1);
  assign last    = (idx_q == {len, {BLK_SHIFT{1'b1}}});

  always_comb begin
    state_n   = state_q;
    idx_n     = idx_q;
    load_wait = 1'b0;
    done      = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_n   = ST_SETUP;
          idx_n     = '0;
          load_wait = 1'b1;
        end
      end
      ST_SETUP: begin
        if (tick) begin
          if (wants_wait(hi_speed, idx_q)) begin
            state_n   = ST_PACE;
            load_wait = 1'b1;
          end else begin
            state_n = ST_RD;
          end
        end
      end
      ST_PACE: begin
        if (tick) state_n = ST_RD;
      end
      ST_RD: begin
        if (mem_ack) state_n = ST_WR;
      end
      ST_WR: begin
        if (mem_ack) begin
          if (last) begin
            state_n = ST_IDLE;
            done    = 1'b1;
          end else begin
            idx_n = idx_inc;
            if (wants_wait(hi_speed, idx_inc)) begin
              state_n   = ST_PACE;
              load_wait = 1'b1;
            end else begin
              state_n = ST_RD;
            end
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  assign rd_addr_n = src + ADDR_W'(idx_n);
  assign wr_addr_n = WIN_BASE | ((dst + ADDR_W'(idx_n)) & WIN_MASK);

  // Memory port and stall are registered from the next-state decode.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      stall     <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
      stall   <= (state_n != ST_IDLE);
      mem_req <= (state_n == ST_RD) || (state_n == ST_WR);
      mem_we  <= (state_n == ST_WR);
      if (state_n == ST_RD) begin
        mem_addr <= rd_addr_n;
      end else if (state_n == ST_WR) begin
        mem_addr <= wr_addr_n;
      end
      if ((state_q == ST_RD) && mem_ack) begin
        mem_wdata <= mem_rdata;
      end
    end
  end
endmodule

// File: rtl/vram_block_dma.sv
module vram_block_dma
  import vdma_pkg::*;
#(
  parameter int                STEP_CYCLES = 4,
  parameter int                BLK_SHIFT   = 4,
  parameter logic [ADDR_W-1:0] WIN_BASE    = 16'h8000,
  parameter logic [ADDR_W-1:0] WIN_MASK    = 16'h1FFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              hi_speed,
  output logic              cpu_stall,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [REG_W-1:0]  mem_wdata,
  input  logic [REG_W-1:0]  mem_rdata,
  input  logic              mem_ack
);
  logic              start, done, load_wait, tick;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [LEN_W-1:0]  len_q;

  vdma_regs #(
    .BLK_SHIFT(BLK_SHIFT)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .reg_sel  (reg_sel),
    .reg_wdata(reg_wdata),
    .busy     (cpu_stall),
    .done     (done),
    .reg_rdata(reg_rdata),
    .start    (start),
    .src_q    (src_q),
    .dst_q    (dst_q),
    .len_q    (len_q)
  );

  vdma_pacer #(
    .STEP_CYCLES(STEP_CYCLES)
  ) u_pacer (
    .clk (clk),
    .rst (rst),
    .load(load_wait),
    .tick(tick)
  );

  vdma_engine #(
    .BLK_SHIFT(BLK_SHIFT),
    .WIN_BASE (WIN_BASE),
    .WIN_MASK (WIN_MASK)
  ) u_engine (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .hi_speed (hi_speed),
    .src      (src_q),
    .dst      (dst_q),
    .len      (len_q),
    .tick     (tick),
    .load_wait(load_wait),
    .done     (done),
    .stall    (cpu_stall),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata),
    .mem_ack  (mem_ack)
  );
endmodule

// File: rtl/vdma_chk.sv
module vdma_chk
  import vdma_pkg::*;
#(
  parameter int                BLK_SHIFT = 4,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 16'h8000,
  parameter logic [ADDR_W-1:0] WIN_MASK  = 16'h1FFF
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [SEL_W-1:0]  reg_sel,
  input logic [REG_W-1:0]  reg_wdata,
  input logic              cpu_stall,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] src_q,
  input logic [ADDR_W-1:0] dst_q,
  input logic [LEN_W-1:0]  len_q
);
  logic ctl_wr_idle;
  assign ctl_wr_idle = reg_wr && (reg_sel == SEL_CTL) && !cpu_stall;

  // R9: memory traffic only while the CPU is held
  p_req_in_xfer_r9: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> cpu_stall);

  // R9: a starting control write raises the stall next cycle
  p_start_stall_r9: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr_idle && !reg_wdata[REG_W-1]) |=> cpu_stall);

  // R5: every write lands inside the window
  p_win_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> ((mem_addr & ~WIN_MASK) == WIN_BASE));

  // R11: an unacknowledged request is held unchanged
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R2: address registers stay block aligned
  p_align_r2: assert property (@(posedge clk) disable iff (rst)
    (src_q[BLK_SHIFT-1:0] == '0) && (dst_q[BLK_SHIFT-1:0] == '0));

  // R7: the count reads all ones once a copy ends
  p_done_len_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_stall) |-> (len_q == '1));

  // R10: registers are frozen while a copy runs
  p_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    cpu_stall |=> (!cpu_stall || ($stable(src_q) && $stable(dst_q) && $stable(len_q))));

  // R8: a deferred-mode write stores the count but never stalls
  p_mode_only_r8: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr_idle && reg_wdata[REG_W-1]) |=> (!cpu_stall && (len_q == $past(reg_wdata[LEN_W-1:0]))));
endmodule

bind vram_block_dma vdma_chk #(
  .BLK_SHIFT(BLK_SHIFT),
  .WIN_BASE (WIN_BASE),
  .WIN_MASK (WIN_MASK)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reg_wr   (reg_wr),
  .reg_sel  (reg_sel),
  .reg_wdata(reg_wdata),
  .cpu_stall(cpu_stall),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_ack  (mem_ack),
  .src_q    (src_q),
  .dst_q    (dst_q),
  .len_q    (len_q)
);

// File: tb/vram_block_dma_tb.sv
module vram_block_dma_tb;
  localparam int S = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic        hi_speed = 1'b0;
  logic        cpu_stall;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'd0;
  logic        mem_ack = 1'b0;

  int total = 0;
  int bad = 0;
  int ack_pct = 100;
  logic [15:0] x_src = 16'd0, x_dst = 16'd0;
  int rd_k = 0, wr_k = 0, mis = 0, stall_cyc = 0, req_cnt = 0;
  logic [15:0] mis_act = 16'd0, mis_exp = 16'd0;

  vram_block_dma #(.STEP_CYCLES(S)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .hi_speed(hi_speed), .cpu_stall(cpu_stall),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] src_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [15:0] win(input logic [15:0] d, input int k);
    return 16'h8000 | ((d + 16'(k)) & 16'h1FFF);
  endfunction

  task automatic check(input bit ok, input string msg, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", msg, act, exp);
    end
  endtask

  // Memory model: acknowledges with a set chance, checks every access in order.
  always @(negedge clk) begin
    if (rst) begin
      mem_ack = 1'b0;
    end else begin
      if (cpu_stall) stall_cyc++;
      if (mem_req) begin
        req_cnt++;
        if ($urandom_range(99) < ack_pct) begin
          mem_ack = 1'b1;
          if (!mem_we) begin
            mem_rdata = src_byte(mem_addr);
            if (mem_addr != x_src + 16'(rd_k)) begin
              mis++; mis_act = mem_addr; mis_exp = x_src + 16'(rd_k);
            end
            rd_k++;
          end else begin
            if (mem_addr != win(x_dst, wr_k)) begin
              mis++; mis_act = mem_addr; mis_exp = win(x_dst, wr_k);
            end else if (mem_wdata != src_byte(x_src + 16'(wr_k))) begin
              mis++; mis_act = {8'h0, mem_wdata}; mis_exp = {8'h0, src_byte(x_src + 16'(wr_k))};
            end
            wr_k++;
          end
        end else begin
          mem_ack = 1'b0;
        end
      end else begin
        mem_ack = 1'b0;
      end
    end
  end

  task automatic wr_reg(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] s, output logic [7:0] d);
    @(negedge clk);
    reg_sel = s;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic run_xfer(input logic [15:0] s, input logic [15:0] d, input logic [6:0] len,
                          input bit hs, input int pct, input bit poke);
    logic [15:0] s_al, d_al, e_src, e_dst;
    logic [7:0]  v;
    int n, cyc, waited;
    s_al = {s[15:4], 4'h0};
    d_al = {d[15:4], 4'h0};
    n = (int'(len) + 1) * 16;
    waited = hs ? n : n / 2;
    wr_reg(3'd0, s[15:8]);
    wr_reg(3'd1, s[7:0]);
    wr_reg(3'd2, d[15:8]);
    wr_reg(3'd3, d[7:0]);
    @(negedge clk);
    hi_speed = hs; ack_pct = pct; x_src = s_al; x_dst = d_al;
    rd_k = 0; wr_k = 0; mis = 0; stall_cyc = 0;
    wr_reg(3'd4, {1'b0, len});
    check(cpu_stall == 1'b1, "R9 stall after start", 32'(cpu_stall), 1);
    if (poke) begin
      wr_reg(3'd0, ~s[15:8]);
      wr_reg(3'd3, 8'h70);
      wr_reg(3'd4, 8'h85);
    end
    cyc = 0;
    while (cpu_stall && cyc < 30000) begin
      @(negedge clk);
      cyc++;
    end
    check(!cpu_stall, "R9 copy finishes", 32'(cpu_stall), 0);
    check(wr_k == n, "R4 bytes written", 32'(wr_k), 32'(n));
    check(rd_k == n, "R11 one read per acknowledge", 32'(rd_k), 32'(n));
    check(mis == 0, "R5 address or data", 32'(mis_act), 32'(mis_exp));
    if (pct == 100)
      check(stall_cyc == S + 2 * n + S * waited, "R6 pacing", 32'(stall_cyc), 32'(S + 2 * n + S * waited));
    e_src = s_al + 16'(n);
    e_dst = d_al + 16'(n);
    rd_reg(3'd0, v); check(v == e_src[15:8], poke ? "R10 src hi" : "R7 src hi", 32'(v), 32'(e_src[15:8]));
    rd_reg(3'd1, v); check(v == e_src[7:0],  "R7 src lo", 32'(v), 32'(e_src[7:0]));
    rd_reg(3'd2, v); check(v == e_dst[15:8], "R7 dst hi", 32'(v), 32'(e_dst[15:8]));
    rd_reg(3'd3, v); check(v == e_dst[7:0],  poke ? "R10 dst lo" : "R7 dst lo", 32'(v), 32'(e_dst[7:0]));
    rd_reg(3'd4, v); check(v == 8'h7F, poke ? "R10 ctl" : "R7 ctl", 32'(v), 32'h7F);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R9 watchdog act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R12 reset state
    check(!cpu_stall && !mem_req, "R12 idle outputs", {cpu_stall, mem_req}, 0);
    for (int i = 0; i < 5; i++) begin
      rd_reg(3'(i), v);
      check(v == 8'h00, "R12 register zero", 32'(v), 0);
    end
    rd_reg(3'd6, v);
    check(v == 8'h00, "R1 unused selector", 32'(v), 0);

    // R1 / R2 register access and alignment
    wr_reg(3'd0, 8'h12); wr_reg(3'd1, 8'h3F); wr_reg(3'd2, 8'h9A); wr_reg(3'd3, 8'hFF);
    rd_reg(3'd0, v); check(v == 8'h12, "R1 src hi", 32'(v), 32'h12);
    rd_reg(3'd1, v); check(v == 8'h30, "R2 src lo", 32'(v), 32'h30);
    rd_reg(3'd2, v); check(v == 8'h9A, "R1 dst hi", 32'(v), 32'h9A);
    rd_reg(3'd3, v); check(v == 8'hF0, "R2 dst lo", 32'(v), 32'hF0);

    // R3 / R8 deferred mode: stored, no traffic
    req_cnt = 0; stall_cyc = 0;
    wr_reg(3'd4, 8'hA5);
    repeat (20) @(negedge clk);
    check(stall_cyc == 0 && req_cnt == 0, "R8 no stall or request", 32'(stall_cyc + req_cnt), 0);
    rd_reg(3'd4, v); check(v == 8'hA5, "R3 ctl readback", 32'(v), 32'hA5);
    rd_reg(3'd0, v); check(v == 8'h12, "R8 src untouched", 32'(v), 32'h12);

    // Directed copies
    run_xfer(16'hC123, 16'h8000, 7'd0, 1'b0, 100, 1'b0);
    run_xfer(16'hC123, 16'h8000, 7'd0, 1'b1, 100, 1'b0);
    run_xfer(16'h4560, 16'h9FF0, 7'd1, 1'b1, 100, 1'b0);
    run_xfer(16'hFFF0, 16'hFFF0, 7'd1, 1'b0, 100, 1'b0);
    run_xfer(16'h2000, 16'h8800, 7'd3, 1'b0, 70, 1'b1);
    run_xfer(16'h0100, 16'h8000, 7'h7F, 1'b1, 100, 1'b0);

    // Random copies
    for (int t = 0; t < 6; t++) begin
      logic [15:0] rs, rdst;
      logic [6:0]  rl;
      bit          rh;
      int          rp;
      rs   = 16'($urandom);
      rdst = 16'($urandom);
      rl   = 7'($urandom_range(0, 9));
      rh   = 1'($urandom_range(0, 1));
      rp   = ($urandom_range(0, 1) == 1) ? 100 : int'($urandom_range(40, 90));
      run_xfer(rs, rdst, rl, rh, rp, 1'($urandom_range(0, 1)));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule